// File: doc/BRIEF.md
# Comparator-First Absolute Difference Unit

This block returns the absolute difference of two unsigned operands. It is built so that the subtraction logic switches as little as possible. A start strobe latches both operands. A step controller then walks a short schedule. The comparison is evaluated first and its outcome is held in a flag. In the following step only one of two subtractor lanes has its input registers loaded: the lane that forms `a - b` when `a` is the larger operand, and the lane that forms `b - a` otherwise. The lane that is not chosen keeps its old inputs, so no transitions reach its logic. A last step steers the chosen lane's difference to the result port and raises a one-cycle done pulse.

A mode input, sampled together with the start strobe, picks a shorter two-step schedule instead. In that schedule the comparison and both subtractor loads happen in the same step, and the selection follows in the next step. This trades one cycle of latency for switching in both lanes. The result stays on the port until a later operation changes it.

Top module: `absd_top`

## Requirements
- R1: After reset `done` is 0 and `result` is 0.
- R2: The result presented with `done` equals |a - b| of the operands latched with the accepted start, taken as unsigned 16-bit values. Equal operands give 0.
- R3: With `two_step` = 0 at acceptance, `done` is high in the third cycle after the clock edge that accepts `start`.
- R4: With `two_step` = 1 at acceptance, `done` is high in the second cycle after the accepting edge.
- R5: `done` is high for exactly one cycle per operation. `result` keeps its value from the done cycle until another start is accepted.
- R6: `start` is accepted only while idle. A strobe from the accepting edge through the done cycle is ignored, and changes on `op_a`, `op_b` or `two_step` in that window do not affect the operation in flight.
- R7: In the three-step schedule only one lane's input registers load, in step 2. The `a - b` lane loads when a > b, and the `b - a` lane loads otherwise. The other lane's input registers keep their values.
- R8: In the two-step schedule both lanes load their input registers in step 1, and the result is still |a - b|.
- R9: The schedule is fixed by the value of `two_step` at the accepting edge. Later changes to `two_step` do not alter latency or result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new operation, honoured only when idle |
| two_step | input | 1 | 1 selects the two-step schedule, sampled with start |
| op_a | input | 16 | First unsigned operand |
| op_b | input | 16 | Second unsigned operand |
| result | output | 16 | Absolute difference, held after done |
| done | output | 1 | One-cycle pulse when result is valid |

## Verification
Two events can fall in the same cycle here: the done pulse of one operation and a fresh start strobe that arrives while the controller is still in its selection step. The bench provokes this by holding `start` high, with changing operands and a flipped mode, from acceptance until after done. It also streams back-to-back requests, so that each strobe lands on the done cycle. A cycle-accurate behavioural model decides that such a strobe must be dropped. It then judges whether done falls at the expected latency and whether the result belongs to the latched operands, not to the later ones.

// File: rtl/absd_pkg.sv
// Package absd_pkg
// Shared width default and the step encoding used by the controller,
// the top level and the checker. Assumes a four-state schedule at most.
package absd_pkg;
    parameter int unsigned DATA_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMP  = 2'd1,
        ST_SUB  = 2'd2,
        ST_SEL  = 2'd3
    } step_e;
endpackage

// File: rtl/absd_ctrl.sv
// Module absd_ctrl
// Step controller. Accepts a start only in ST_IDLE, latches the schedule
// choice, registers the comparator outcome in the compare step and
// issues per-lane load enables. Assumes cmp_gt is valid in ST_CMP.
module absd_ctrl
    import absd_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             two_step,
    input  logic             cmp_gt,
    output step_e            state,
    output logic             fast_q,
    output logic             gt_q,
    output logic             capture,
    output logic [LANES-1:0] lane_ld,
    output logic             done
);
    // Advance the schedule and hold the mode and comparison flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            fast_q <= 1'b0;
            gt_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    fast_q <= two_step;
                    state  <= ST_CMP;
                end
                ST_CMP: begin
                    gt_q  <= cmp_gt;
                    state <= fast_q ? ST_SEL : ST_SUB;
                end
                ST_SUB:  state <= ST_SEL;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode operand capture, lane loads and the done pulse from the step.
    always_comb begin
        capture    = (state == ST_IDLE) && start;
        done       = (state == ST_SEL);
        // lane 0 forms a-b, lane 1 forms b-a
        lane_ld[0] = ((state == ST_CMP) && fast_q) || ((state == ST_SUB) && gt_q);
        lane_ld[1] = ((state == ST_CMP) && fast_q) || ((state == ST_SUB) && !gt_q);
    end
endmodule

// File: rtl/absd_lane.sv
// Module absd_lane
// One subtractor lane with load-enabled input registers. When load is low
// the registers hold, so the subtractor sees no transitions. SWAP=1 makes
// the lane compute y - x instead of x - y.
module absd_lane #(
    parameter int unsigned W    = 16,
    parameter bit          SWAP = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] lhs_q,
    output logic [W-1:0] rhs_q,
    output logic [W-1:0] diff
);
    // Capture the minuend and subtrahend only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lhs_q <= '0;
            rhs_q <= '0;
        end else if (load) begin
            lhs_q <= SWAP ? y : x;
            rhs_q <= SWAP ? x : y;
        end
    end

    // Subtract the registered inputs.
    always_comb diff = lhs_q - rhs_q;
endmodule

// File: rtl/absd_top.sv
// Module absd_top
// Absolute difference with a comparator-first schedule. Operands are
// latched at start. The comparison drives the choice of the single lane
// to load (three-step mode), or both lanes load at once (two-step mode).
// The registered comparison picks the lane output for the result.
module absd_top
    import absd_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         two_step,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] result,
    output logic         done
);
    localparam int unsigned LANES = 2;

    step_e              state;
    logic               fast_q;
    logic               gt_q;
    logic               capture;
    logic [LANES-1:0]   lane_ld;
    logic [W-1:0]       opa_q;
    logic [W-1:0]       opb_q;
    logic               cmp_gt;
    logic [W-1:0]       lane_lhs  [LANES];
    logic [W-1:0]       lane_rhs  [LANES];
    logic [W-1:0]       lane_diff [LANES];

    // Latch the operands of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
        end else if (capture) begin
            opa_q <= op_a;
            opb_q <= op_b;
        end
    end

    // Comparator evaluated in the first step.
    always_comb cmp_gt = (opa_q > opb_q);

    absd_ctrl #(.LANES(LANES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .two_step (two_step),
        .cmp_gt   (cmp_gt),
        .state    (state),
        .fast_q   (fast_q),
        .gt_q     (gt_q),
        .capture  (capture),
        .lane_ld  (lane_ld),
        .done     (done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        absd_lane #(.W(W), .SWAP(g == 1)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (lane_ld[g]),
            .x     (opa_q),
            .y     (opb_q),
            .lhs_q (lane_lhs[g]),
            .rhs_q (lane_rhs[g]),
            .diff  (lane_diff[g])
        );
    end

    // Output selector steered by the registered comparison.
    always_comb result = gt_q ? lane_diff[0] : lane_diff[1];
endmodule

// File: rtl/absd_checker.sv
// Module absd_checker
// Property checks on absd_top, attached by bind. Observes ports plus the
// controller step, the latched operands and the lane input registers.
module absd_checker
    import absd_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         two_step,
    input logic [W-1:0] result,
    input logic         done,
    input step_e        state,
    input logic         fast_q,
    input logic         gt_q,
    input logic [W-1:0] opa_q,
    input logic [W-1:0] opb_q,
    input logic [W-1:0] l0_lhs,
    input logic [W-1:0] l0_rhs,
    input logic [W-1:0] l1_lhs,
    input logic [W-1:0] l1_rhs
);
    a_r2_result_value: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result == ((opa_q > opb_q) ? opa_q - opb_q : opb_q - opa_q));

    a_r3_three_step_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_IDLE && !two_step) |-> ##3 done);

    a_r4_two_step_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_IDLE && two_step) |-> ##2 done);

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable(result));

    a_r6_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(opa_q) && $stable(opb_q));

    a_r7_swap_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUB && gt_q) |=> $stable(l1_lhs) && $stable(l1_rhs));

    a_r7_fwd_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUB && !gt_q) |=> $stable(l0_lhs) && $stable(l0_rhs));

    a_r8_both_lanes_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMP && fast_q) |=> (l0_lhs == opa_q) && (l1_lhs == opb_q));
endmodule

bind absd_top absd_checker #(.W(W)) u_absd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .two_step (two_step),
    .result   (result),
    .done     (done),
    .state    (state),
    .fast_q   (fast_q),
    .gt_q     (gt_q),
    .opa_q    (opa_q),
    .opb_q    (opb_q),
    .l0_lhs   (lane_lhs[0]),
    .l0_rhs   (lane_rhs[0]),
    .l1_lhs   (lane_lhs[1]),
    .l1_rhs   (lane_rhs[1])
);

// File: tb/test_absd_top.sv
// Bench for absd_top: a behavioural cycle model checked on every falling
// edge, plus directed runs that measure latency and result per operation.
module test_absd_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         two_step = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] result;
    logic         done;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    // model state
    bit         m_on = 1'b0;
    int         m_cnt = 0;
    bit         m_done = 1'b0;
    bit         m_valid = 1'b1;
    int         m_res = 0;
    int         m_pend = 0;
    bit         m_fast = 1'b0;

    always #5 clk = ~clk;

    absd_top i_absd_top (
        .clk(clk), .rst_n(rst_n), .start(start), .two_step(two_step),
        .op_a(op_a), .op_b(op_b), .result(result), .done(done)
    );

    function automatic int absdiff(int a, int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Cycle model: compare this cycle, then advance with sampled inputs.
    always @(negedge clk) begin
        cycles++;
        if (m_on && rst_n) begin
            check(done == m_done, m_fast ? "R4 done timing" : "R3 done timing",
                  int'(done), int'(m_done));
            if (m_valid)
                check(result == W'(m_res), m_done ? "R2 result" : "R5 result hold",
                      int'(result), m_res);
            if (m_cnt == 0 && !m_done) begin
                if (start) begin   // R6: only accepted while idle
                    m_fast  = two_step;
                    m_cnt   = two_step ? 1 : 2;
                    m_pend  = absdiff(int'(op_a), int'(op_b));
                    m_valid = 1'b0;
                end
                m_done = 1'b0;
            end else if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done  = 1'b1;
                    m_valid = 1'b1;
                    m_res   = m_pend;
                end
            end else begin
                m_done = 1'b0;
            end
        end
    end

    // Directed run: one strobe, optional disturbance while busy, measured latency.
    task automatic run(int a, int b, bit fast, bit disturb, string tag);
        int n;
        @(posedge clk); #1;
        start = 1'b1; op_a = W'(a); op_b = W'(b); two_step = fast;
        @(posedge clk); #1;
        start = disturb; two_step = disturb ? ~fast : fast;
        if (disturb) begin op_a = ~W'(a); op_b = W'(a) ^ 16'h5a5a; end
        n = 0;
        while (n < 10) begin
            @(negedge clk);
            n++;
            if (done) break;
        end
        check(n == (fast ? 2 : 3), tag, n, fast ? 2 : 3);
        check(result == W'(absdiff(a, b)), tag, int'(result), absdiff(a, b));
        @(posedge clk); #1;
        start = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(result == '0, "R1 result after reset", int'(result), 0);
        m_on = 1'b1;

        // R7: three-step, a>b loads only the a-b lane; a<b only the b-a lane
        run(100, 7, 1'b0, 1'b0, "R7 a>b three-step");
        run(7, 100, 1'b0, 1'b0, "R7 a<b three-step");
        run(0, 0, 1'b0, 1'b0, "R2 zero operands");
        run(16'hffff, 0, 1'b0, 1'b0, "R2 max minus zero");
        run(0, 16'hffff, 1'b0, 1'b0, "R2 zero minus max");
        run(1234, 1234, 1'b0, 1'b0, "R2 equal operands");
        // R8: two-step schedule, both directions
        run(500, 20, 1'b1, 1'b0, "R8 a>b two-step");
        run(20, 500, 1'b1, 1'b0, "R8 a<b two-step");
        run(16'hffff, 16'hffff, 1'b1, 1'b0, "R8 equal max two-step");
        // R6 and R9: strobes, operand and mode changes while busy are ignored
        run(40000, 3, 1'b0, 1'b1, "R6 R9 disturbed three-step");
        run(3, 40000, 1'b1, 1'b1, "R6 R9 disturbed two-step");

        // Back-to-back: start held, so strobes land on done cycles (R6)
        @(posedge clk); #1;
        start = 1'b1;
        for (int i = 0; i < 60; i++) begin
            op_a = W'($urandom); op_b = W'($urandom); two_step = 1'($urandom);
            @(posedge clk); #1;
        end
        start = 1'b0;

        // Random traffic with idle gaps; the model checks every cycle (R2, R5)
        for (int i = 0; i < 400; i++) begin
            op_a = W'($urandom); op_b = ($urandom % 8 == 0) ? op_a : W'($urandom);
            two_step = 1'($urandom);
            start = 1'($urandom % 3 == 0);
            @(posedge clk); #1;
        end
        start = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        wait (cycles > 100000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule